// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits between the serial protocol engine of a small byte-addressed nonvolatile memory and its storage array. Once the protocol engine has received the start address of a write, it hands over each received data byte with a one-cycle strobe. The block places each byte in a 16-slot page buffer. Slot positions wrap inside the page that the start address selects. When more than 16 bytes arrive, the oldest buffered byte is overwritten by the newest.

A STOP strobe ends the transaction. If at least one byte was buffered and the write-protect level is low, the block raises `busy` for a fixed, parameterised number of clocks. This models the self-timed erase-and-program cycle. Early in that window, the block issues one array write per buffered slot. The protocol engine uses `busy` to withhold acknowledge. A START strobe before STOP, a STOP with nothing buffered, or a STOP while write protect is high discards the buffer without programming anything.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` and `arr_we` are low.
- R2: An accepted `addr_load` latches `start_addr`. Data byte number i (counted from 0) goes to slot (`start_addr[3:0]` + i) mod 16. Every array write of the commit carries `arr_addr` = {`start_addr[10:4]`, slot}.
- R3: Slot positions wrap from 15 to 0 without changing address bits 10:4.
- R4: When more than 16 bytes arrive, each slot holds the last byte written to it, so only the newest 16 bytes are kept.
- R5: A commit writes exactly the slots filled in the transaction, one per clock, in ascending slot order, within the first 16 cycles of the busy window. Unfilled locations of the page get no write.
- R6: A STOP strobe accepted with at least one buffered byte and `wp` low raises `busy` on the next clock edge. `busy` then stays high for exactly PROG_CYCLES clocks.
- R7: A STOP while `wp` is high starts no busy window and issues no array write, and the buffered bytes are discarded.
- R8: A STOP with no buffered byte starts no busy window and issues no array write.
- R9: A START strobe discards the buffer. Data bytes that arrive after START or STOP and before the next `addr_load` are ignored.
- R10: While `busy` is high, `addr_load`, data bytes, START and STOP are ignored. A STOP within the window does not start a second window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 11 | Byte address sent in the address phase |
| addr_load | input | 1 | One-cycle strobe: address phase complete, `start_addr` valid |
| byte_valid | input | 1 | One-cycle strobe: `byte_data` holds a received data byte |
| byte_data | input | 8 | Received data byte |
| start_evt | input | 1 | One-cycle strobe: bus START detected |
| stop_evt | input | 1 | One-cycle strobe: bus STOP detected |
| wp | input | 1 | Write-protect level, sampled when STOP is seen |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 11 | Array write address |
| arr_data | output | 8 | Array write data |

## Verification
The assertions assume that the strobes come from a protocol engine, so each strobe lasts one cycle and at most one of them is high in a given cycle. The assertions also assume PROG_CYCLES is at least 16, so the commit scan always fits inside the busy window. The stimulus drives every strobe for exactly one clock, keeps the strobes apart, and uses a programming length of 40 clocks. Strobes sent during the busy window are also single-cycle. They test that the inputs are ignored, not the priority between strobes that arrive together.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FILL = 2'd1,
    PH_PROG = 2'd2
  } pwb_phase_e;
endpackage

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [ADDR_W-1:0]          load_addr,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       clear,
  input  logic [SLOT_W-1:0]          rd_slot,
  output logic [ADDR_W-SLOT_W-1:0]   page_q,
  output logic [(1<<SLOT_W)-1:0]     mask_q,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int unsigned SLOTS = 1 << SLOT_W;

  function automatic logic [SLOT_W-1:0] slot_after(input logic [SLOT_W-1:0] s);
    return s + SLOT_W'(1);
  endfunction

  function automatic logic [ADDR_W-SLOT_W-1:0] page_part(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SLOT_W];
  endfunction

  logic [SLOT_W-1:0] ptr_q;
  logic [DATA_W-1:0] slot_q [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else if (load) begin
      ptr_q  <= load_addr[SLOT_W-1:0];
      page_q <= page_part(load_addr);
    end else if (wr_en) begin
      ptr_q  <= slot_after(ptr_q);
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (ptr_q == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
        mask_q[g] <= 1'b0;
      end else begin
        if (hit) slot_q[g] <= wr_data;
        if (clear) mask_q[g] <= 1'b0;
        else if (hit) mask_q[g] <= 1'b1;
      end
    end
  end

  assign rd_data = slot_q[rd_slot];

  // R2
  slot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |=> mask_q[$past(ptr_q)]);
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int unsigned PROG_CYCLES = 100000,
  parameter int unsigned CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done
);
  assign done = run && (cnt_q == CNT_W'(PROG_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (launch) cnt_q <= '0;
    else if (done)   cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + CNT_W'(1);
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CNT_W'(PROG_CYCLES)));

  // R6
  launch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (cnt_q == '0));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned SLOT_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROG_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              addr_load,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              wp,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  import pwb_pkg::*;

  localparam int unsigned SLOTS = 1 << SLOT_W;
  localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);

  pwb_phase_e phase_q;
  logic [CNT_W-1:0]        cnt;
  logic [ADDR_W-SLOT_W-1:0] page;
  logic [SLOTS-1:0]        mask;
  logic [SLOT_W-1:0]       scan_slot;
  logic [DATA_W-1:0]       scan_data;

  // named internal events
  logic idle_ok, take_start, take_stop, take_addr;
  logic accept_byte, launch_prog, drop_buf, prog_done, store_clear, in_scan;

  assign busy        = (phase_q == PH_PROG);
  assign idle_ok     = !busy;
  assign take_start  = idle_ok && start_evt;
  assign take_stop   = idle_ok && !start_evt && stop_evt;
  assign take_addr   = idle_ok && !start_evt && !stop_evt && addr_load;
  assign accept_byte = idle_ok && (phase_q == PH_FILL) && !start_evt
                       && !stop_evt && !addr_load && byte_valid;
  assign launch_prog = take_stop && (phase_q == PH_FILL) && (|mask) && !wp;
  assign drop_buf    = take_start || (take_stop && !launch_prog);
  assign store_clear = drop_buf || take_addr || prog_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else if (busy) begin
      if (prog_done) phase_q <= PH_IDLE;
    end
    else if (launch_prog) phase_q <= PH_PROG;
    else if (drop_buf)    phase_q <= PH_IDLE;
    else if (take_addr)   phase_q <= PH_FILL;
  end

  pwb_store #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .load(take_addr), .load_addr(start_addr),
    .wr_en(accept_byte), .wr_data(byte_data),
    .clear(store_clear), .rd_slot(scan_slot),
    .page_q(page), .mask_q(mask), .rd_data(scan_data)
  );

  pwb_timer #(.PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .launch(launch_prog), .run(busy),
    .cnt_q(cnt), .done(prog_done)
  );

  assign scan_slot = cnt[SLOT_W-1:0];
  assign in_scan   = busy && (cnt < CNT_W'(SLOTS));
  assign arr_we    = in_scan && mask[scan_slot];
  assign arr_addr  = {page, scan_slot};
  assign arr_data  = scan_data;

  // R7
  wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wp && stop_evt));

  // R5
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr[SLOT_W-1:0] > $past(arr_addr[SLOT_W-1:0])));

  // R5
  we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> ($stable(mask) && $stable(page) && busy));

  // R6
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mask == '0));
endmodule

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;
  localparam int PROG = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] start_addr = '0;
  logic        addr_load = 1'b0, byte_valid = 1'b0, start_evt = 1'b0, stop_evt = 1'b0, wp = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        busy, arr_we;
  logic [10:0] arr_addr;
  logic [7:0]  arr_data;

  int checks = 0;
  int fails  = 0;

  logic [10:0] log_addr [32];
  logic [7:0]  log_data [32];
  int wr_cnt = 0;
  int busy_cnt = 0;

  logic [7:0] exp_d [16];
  bit         exp_v [16];

  always #10 clk = ~clk;

  page_write_buffer #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .addr_load(addr_load),
    .byte_valid(byte_valid), .byte_data(byte_data), .start_evt(start_evt),
    .stop_evt(stop_evt), .wp(wp), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data)
  );

  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      if (wr_cnt < 32) begin
        log_addr[wr_cnt] = arr_addr;
        log_data[wr_cnt] = arr_data;
      end
      wr_cnt++;
    end
    if (rst_n && busy) busy_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_cnt = 0;
    busy_cnt = 0;
    for (int s = 0; s < 16; s++) begin exp_v[s] = 1'b0; exp_d[s] = '0; end
  endtask

  task automatic do_addr(input logic [10:0] a);
    @(negedge clk); start_addr = a; addr_load = 1'b1;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); byte_data = d; byte_valid = 1'b1;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0;
  endtask

  task automatic settle();
    repeat (PROG + 8) @(negedge clk);
  endtask

  // reference placement: byte i lands at (low nibble + i) modulo page size
  task automatic send_bytes(input logic [10:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      int s;
      s = (int'(a) % 16 + i) % 16;
      exp_d[s] = seed + 8'(i);
      exp_v[s] = 1'b1;
      do_byte(seed + 8'(i));
    end
  endtask

  task automatic verify_commit(input string tag, input logic [10:0] a);
    int k;
    int n;
    k = 0;
    n = 0;
    for (int s = 0; s < 16; s++) if (exp_v[s]) n++;
    chk(wr_cnt == n, {tag, " write count"}, wr_cnt, n);
    for (int s = 0; s < 16; s++) begin
      if (exp_v[s] && k < wr_cnt && k < 32) begin
        logic [10:0] ea;
        ea = (a / 16) * 16 + 11'(s);
        chk(log_addr[k] == ea, {tag, " address"}, log_addr[k], ea);
        chk(log_data[k] == exp_d[s], {tag, " data"}, log_data[k], exp_d[s]);
        k++;
      end
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(arr_we == 1'b0, "R1 arr_we after reset", arr_we, 0);
  endtask

  task automatic t_basic();
    clear_log();
    do_addr(11'h123);
    send_bytes(11'h123, 4, 8'hA0);
    do_stop();
    chk(busy == 1'b1, "R6 busy next edge after stop", busy, 1);
    settle();
    chk(busy_cnt == PROG, "R6 busy length", busy_cnt, PROG);
    verify_commit("R2 R5 basic", 11'h123);
  endtask

  task automatic t_wrap();
    clear_log();
    do_addr(11'h7FD);
    send_bytes(11'h7FD, 5, 8'h30);
    do_stop();
    settle();
    verify_commit("R3 wrap", 11'h7FD);
  endtask

  task automatic t_over();
    clear_log();
    do_addr(11'h040);
    send_bytes(11'h040, 20, 8'h10);
    do_stop();
    settle();
    chk(exp_d[0] == 8'h20, "R4 model slot0 newest", exp_d[0], 8'h20);
    verify_commit("R4 overwrite", 11'h040);
  endtask

  task automatic t_wp();
    clear_log();
    wp = 1'b1;
    do_addr(11'h200);
    send_bytes(11'h200, 3, 8'h55);
    do_stop();
    settle();
    wp = 1'b0;
    chk(busy_cnt == 0, "R7 no busy under wp", busy_cnt, 0);
    chk(wr_cnt == 0, "R7 no write under wp", wr_cnt, 0);
    clear_log();
    do_addr(11'h20A);
    send_bytes(11'h20A, 1, 8'h77);
    do_stop();
    settle();
    verify_commit("R7 discarded bytes not committed later", 11'h20A);
  endtask

  task automatic t_empty();
    clear_log();
    do_addr(11'h300);
    do_stop();
    settle();
    chk(busy_cnt == 0, "R8 no busy on empty stop", busy_cnt, 0);
    chk(wr_cnt == 0, "R8 no write on empty stop", wr_cnt, 0);
  endtask

  task automatic t_start();
    clear_log();
    do_addr(11'h111);
    send_bytes(11'h111, 3, 8'h90);
    do_start();
    do_stop();
    settle();
    chk(busy_cnt == 0, "R9 start discards buffer", busy_cnt, 0);
    do_byte(8'hEE);
    do_stop();
    settle();
    chk(wr_cnt == 0, "R9 bytes without address ignored", wr_cnt, 0);
    chk(busy_cnt == 0, "R9 no busy without address", busy_cnt, 0);
  endtask

  task automatic t_busy_ignore();
    clear_log();
    do_addr(11'h0F8);
    send_bytes(11'h0F8, 1, 8'hC3);
    do_stop();
    do_addr(11'h400);
    do_byte(8'h11);
    do_byte(8'h22);
    do_stop();
    settle();
    chk(busy_cnt == PROG, "R10 single busy window", busy_cnt, PROG);
    verify_commit("R10 only first transaction", 11'h0F8);
    clear_log();
    do_stop();
    settle();
    chk(busy_cnt == 0, "R10 strobes in window left no state", busy_cnt, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_wrap();
    t_over();
    t_wp();
    t_empty();
    t_start();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule